// File: doc/BRIEF.md
# Shared-Line Key Matrix Sampler

This block scans a matrix of ten source lines by two return inputs. The ten source lines are also display segment outputs. Between scans they pass the segment data through. After each display cycle they carry a walking one, one line at a time, while the two return inputs are sampled. A full scan is committed to a key buffer as a single unit when the last line has been sampled. Scanning runs whether the display is enabled or not.

The buffer is read as five bytes. Each byte packs the two return samples of an odd source line and of the even line after it, so byte 0 covers lines 1 and 2 and byte 4 covers lines 9 and 10. A read command takes a snapshot of the committed buffer and sets a byte pointer to zero. Each byte-advance pulse then steps the pointer. The serial shifter outside the block presents the selected byte least significant bit first.

Top module: `key_matrix_sampler`

## Requirements
- R1: While no key phase is running, `seg_out` equals `seg_in` when `disp_on` is 1 and is all zero when `disp_on` is 0.
- R2: A one-cycle pulse on `cycle_end` while idle starts a key phase on the next clock. In that phase exactly one `seg_out` bit is high, stepping from bit 0 to bit 9. Each line stays high for `SETTLE_CYC` cycles.
- R3: A `cycle_end` pulse that arrives during a key phase has no effect. The phase keeps its line order and its length.
- R4: The key phase runs and stores results whether `disp_on` is 0 or 1.
- R5: `k_in` is sampled on the last clock of each line's window. The buffer that reads see changes only on the clock that samples line 10, and nothing in it changes earlier in the phase.
- R6: In each read byte, bit 0 holds `k_in[0]` and bit 1 holds `k_in[1]` for the odd line. Bit 3 holds `k_in[0]` and bit 4 holds `k_in[1]` for the even line. Bits 2, 5, 6 and 7 read zero.
- R7: Byte n (n = 0 to 4) covers source lines 2n+1 and 2n+2, which are `seg_out` bits 2n and 2n+1.
- R8: `rd_start` copies the committed buffer into a read snapshot and sets `rd_ptr` to 0. A commit after that does not change the bytes read until the next `rd_start`.
- R9: `rd_next` advances `rd_ptr` by one and wraps from 4 to 0. When `rd_start` and `rd_next` arrive in the same cycle, `rd_start` wins.
- R10: After reset the block is idle, all key bits are zero and `rd_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | Display enable for the segment pass-through |
| seg_in | input | N_SRC | Segment data from the display scanner |
| cycle_end | input | 1 | Pulse marking the end of a display cycle |
| k_in | input | 2 | Key return inputs |
| rd_start | input | 1 | Read command start: snapshot and pointer clear |
| rd_next | input | 1 | Advance to the next read byte |
| seg_out | output | N_SRC | Shared segment / key source lines |
| rd_byte | output | 8 | Packed key byte at the read pointer |
| rd_ptr | output | 3 | Index of the byte being read |

## Verification
A wrong line counter or settle counter shows on `seg_out` in the same cycle. The walking one lands on the wrong bit, or holds for the wrong number of cycles. A stage bit written to the wrong position, or a commit at the wrong time, stays hidden until the next `rd_start`. The bench therefore opens a read both in the middle of a scan and after it, and compares every byte against a model that samples the key matrix on its own. A faulty pointer or snapshot shows as a wrong `rd_byte` on the first advance after it.

// File: rtl/ksm_pkg.sv
package ksm_pkg;
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_KEY  = 1'b1
    } scan_st_e;

    localparam int KEY_BYTE_W = 8;
    localparam int KEY_RET_N  = 2;
endpackage

// File: rtl/ksm_scan_ctrl.sv
module ksm_scan_ctrl
    import ksm_pkg::*;
#(
    parameter int N_SRC      = 10,
    parameter int SETTLE_CYC = 2,
    localparam int LINE_W    = $clog2(N_SRC),
    localparam int CNT_W     = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_end,
    output logic              busy,
    output logic [LINE_W-1:0] line,
    output logic              sample,
    output logic              last
);
    typedef struct packed {
        scan_st_e          st;
        logic [LINE_W-1:0] line;
        logic [CNT_W-1:0]  cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d  = ctl_q;
        sample = (ctl_q.st == SC_KEY) && (ctl_q.cnt == CNT_W'(SETTLE_CYC - 1));
        last   = sample && (ctl_q.line == LINE_W'(N_SRC - 1));
        if (ctl_q.st == SC_IDLE) begin
            if (cycle_end) begin
                ctl_d.st   = SC_KEY;
                ctl_d.line = '0;
                ctl_d.cnt  = '0;
            end
        end else if (sample) begin
            ctl_d.cnt = '0;
            if (last) begin
                ctl_d.st = SC_IDLE;
            end else begin
                ctl_d.line = ctl_q.line + 1'b1;
            end
        end else begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: SC_IDLE, line: '0, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy = (ctl_q.st == SC_KEY);
    assign line = ctl_q.line;

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample) |=> $stable(line)); // R2
    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(line) < N_SRC)); // R2
    AST_PHASE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy); // R3
endmodule

// File: rtl/ksm_key_store.sv
module ksm_key_store
    import ksm_pkg::*;
#(
    parameter int N_SRC    = 10,
    localparam int LINE_W  = $clog2(N_SRC),
    localparam int KEY_W   = N_SRC * KEY_RET_N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 last,
    input  logic [LINE_W-1:0]    line,
    input  logic [KEY_RET_N-1:0] k_in,
    output logic [KEY_W-1:0]     keys
);
    typedef struct packed {
        logic [KEY_W-1:0] stage;
        logic [KEY_W-1:0] keys;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample) begin
            st_d.stage[KEY_RET_N*int'(line) +: KEY_RET_N] = k_in;
        end
        if (last) begin
            st_d.keys = st_d.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign keys = st_q.keys;

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(keys)); // R5
    AST_BUF_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (keys[KEY_W-1 -: KEY_RET_N] == $past(k_in))); // R5
endmodule

// File: rtl/ksm_read_port.sv
module ksm_read_port
    import ksm_pkg::*;
#(
    parameter int N_SRC     = 10,
    localparam int KEY_W    = N_SRC * KEY_RET_N,
    localparam int N_BYTES  = N_SRC / 2,
    localparam int PTR_W    = $clog2(N_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [KEY_W-1:0]      keys,
    input  logic                  rd_start,
    input  logic                  rd_next,
    output logic [KEY_BYTE_W-1:0] rd_byte,
    output logic [PTR_W-1:0]      rd_ptr
);
    typedef struct packed {
        logic [KEY_W-1:0] snap;
        logic [PTR_W-1:0] ptr;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [KEY_BYTE_W-1:0] packed_b [N_BYTES];

    for (genvar j = 0; j < N_BYTES; j++) begin : g_pack
        localparam int ODD  = 4 * j;
        localparam int EVEN = 4 * j + 2;
        assign packed_b[j] = {3'b000,
                              rd_q.snap[EVEN+1], rd_q.snap[EVEN],
                              1'b0,
                              rd_q.snap[ODD+1],  rd_q.snap[ODD]};
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_start) begin
            rd_d.snap = keys;
            rd_d.ptr  = '0;
        end else if (rd_next) begin
            rd_d.ptr = (rd_q.ptr == PTR_W'(N_BYTES - 1)) ? '0 : rd_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_ptr  = rd_q.ptr;
    assign rd_byte = packed_b[rd_q.ptr];

    AST_DC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte & 8'hE4) == 8'h00); // R6
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_ptr) < N_BYTES); // R9
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_next && !rd_start && rd_ptr == PTR_W'(N_BYTES - 1)) |=> (rd_ptr == '0)); // R9
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (rd_ptr == '0)); // R8
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_start && !rd_next) |=> $stable(rd_byte)); // R8
endmodule

// File: rtl/key_matrix_sampler.sv
module key_matrix_sampler
    import ksm_pkg::*;
#(
    parameter int N_SRC      = 10,
    parameter int SETTLE_CYC = 2,
    localparam int LINE_W    = $clog2(N_SRC),
    localparam int KEY_W     = N_SRC * KEY_RET_N,
    localparam int PTR_W     = $clog2(N_SRC / 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  disp_on,
    input  logic [N_SRC-1:0]      seg_in,
    input  logic                  cycle_end,
    input  logic [KEY_RET_N-1:0]  k_in,
    input  logic                  rd_start,
    input  logic                  rd_next,
    output logic [N_SRC-1:0]      seg_out,
    output logic [KEY_BYTE_W-1:0] rd_byte,
    output logic [PTR_W-1:0]      rd_ptr
);
    logic              busy;
    logic              sample;
    logic              last;
    logic [LINE_W-1:0] line;
    logic [KEY_W-1:0]  keys;
    logic [N_SRC-1:0]  src_hot;

    ksm_scan_ctrl #(.N_SRC(N_SRC), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cycle_end(cycle_end),
        .busy(busy), .line(line), .sample(sample), .last(last)
    );

    ksm_key_store #(.N_SRC(N_SRC)) u_store (
        .clk(clk), .rst_n(rst_n), .sample(sample), .last(last),
        .line(line), .k_in(k_in), .keys(keys)
    );

    ksm_read_port #(.N_SRC(N_SRC)) u_read (
        .clk(clk), .rst_n(rst_n), .keys(keys), .rd_start(rd_start),
        .rd_next(rd_next), .rd_byte(rd_byte), .rd_ptr(rd_ptr)
    );

    always_comb begin
        src_hot = '0;
        for (int i = 0; i < N_SRC; i++) begin
            src_hot[i] = (LINE_W'(i) == line);
        end
    end

    always_comb begin
        if (busy) begin
            seg_out = src_hot;
        end else if (disp_on) begin
            seg_out = seg_in;
        end else begin
            seg_out = '0;
        end
    end

    AST_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(seg_out) == 1)); // R2
    AST_DARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !disp_on) |-> (seg_out == '0)); // R1
endmodule

// File: tb/sim_key_matrix_sampler.sv
module sim_key_matrix_sampler;
    localparam int NS  = 10;
    localparam int SET = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_on = 1'b0;
    logic [NS-1:0] seg_in = '0;
    logic cycle_end = 1'b0;
    logic [1:0] k_in;
    logic rd_start = 1'b0;
    logic rd_next = 1'b0;
    logic [NS-1:0] seg_out;
    logic [7:0] rd_byte;
    logic [2:0] rd_ptr;

    logic [2*NS-1:0] prs = '0;
    int checks = 0;
    int errors = 0;
    string rd_tag = "R10";
    bit done = 1'b0;

    always #2 clk = ~clk;

    key_matrix_sampler #(.N_SRC(NS), .SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .seg_in(seg_in),
        .cycle_end(cycle_end), .k_in(k_in), .rd_start(rd_start),
        .rd_next(rd_next), .seg_out(seg_out), .rd_byte(rd_byte), .rd_ptr(rd_ptr)
    );

    // Key matrix: a pressed key connects a source line to a return input.
    always_comb begin
        k_in = 2'b00;
        for (int i = 0; i < NS; i++) begin
            if (seg_out[i]) k_in = k_in | {prs[2*i+1], prs[2*i]};
        end
    end

    // Reference model
    bit m_act;
    int m_line, m_cnt, m_ptr;
    bit m_late;
    logic [2*NS-1:0] m_stage, m_buf, m_snap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_line = 0; m_cnt = 0; m_ptr = 0; m_late = 0;
            m_stage = '0; m_buf = '0; m_snap = '0;
        end else begin
            if (rd_start) begin
                m_snap = m_buf; m_ptr = 0;
            end else if (rd_next) begin
                m_ptr = (m_ptr + 1) % (NS / 2);
            end
            if (m_act) begin
                if (cycle_end) m_late = 1;
                if (m_cnt == SET - 1) begin
                    m_stage[2*m_line]   = prs[2*m_line];
                    m_stage[2*m_line+1] = prs[2*m_line+1];
                    m_cnt = 0;
                    if (m_line == NS - 1) begin
                        m_buf = m_stage; m_act = 0;
                    end else begin
                        m_line++;
                    end
                end else begin
                    m_cnt++;
                end
            end else if (cycle_end) begin
                m_act = 1; m_line = 0; m_cnt = 0; m_late = 0;
            end
        end
    end

    function automatic logic [7:0] exp_byte(int n);
        logic [7:0] b = '0;
        b[0] = m_snap[4*n];
        b[1] = m_snap[4*n+1];
        b[3] = m_snap[4*n+2];
        b[4] = m_snap[4*n+3];
        return b;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NS-1:0] es;
            string st;
            if (m_act) begin
                es = NS'(1) << m_line;
                st = m_late ? "R3" : (disp_on ? "R2" : "R4");
            end else begin
                es = disp_on ? seg_in : '0;
                st = "R1";
            end
            check({st, " seg_out"}, int'(seg_out), int'(es));
            check({rd_tag, " rd_byte"}, int'(rd_byte), int'(exp_byte(m_ptr)));
            check("R9 rd_ptr", int'(rd_ptr), m_ptr);
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_end();
        cycle_end = 1'b1; step(1); cycle_end = 1'b0;
    endtask

    task automatic read_all(int n);
        rd_start = 1'b1; step(1); rd_start = 1'b0;
        repeat (n) begin
            rd_next = 1'b1; step(1); rd_next = 1'b0; step(1);
        end
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        check("R10 reset seg_out", int'(seg_out), 0);
        check("R10 reset rd_byte", int'(rd_byte), 0);
        check("R10 reset rd_ptr", int'(rd_ptr), 0);
        step(1);
        // R1 pass-through and blanking
        disp_on = 1'b1; seg_in = 10'h2A5; step(3);
        seg_in = 10'h15A; step(2);
        disp_on = 1'b0; step(3);
        // R2 R3 R6 R7: scan with display on, late cycle_end ignored
        rd_tag = "R7";
        prs = 20'hB5C3E;
        disp_on = 1'b1; seg_in = 10'h3FF;
        pulse_end(); step(5);
        pulse_end(); step(NS * SET + 4);
        read_all(6);
        // R4 R5 R8: display off, reads opened mid-scan keep old data
        rd_tag = "R5";
        disp_on = 1'b0;
        prs = 20'h4A1D6;
        pulse_end(); step(6);
        rd_tag = "R8";
        read_all(2);
        step(NS * SET);
        read_all(0);
        rd_next = 1'b1; step(2); rd_next = 1'b0; step(2);
        rd_tag = "R6";
        read_all(5);
        // R9: start wins over next in the same cycle
        rd_next = 1'b1; step(2);
        rd_start = 1'b1; step(1);
        rd_start = 1'b0; rd_next = 1'b0; step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule